// File: doc/BRIEF.md
# Staggered Multi-Channel Servo Pulse Generator

The block drives a bank of servo control lines from a flat array of pulse widths given in microseconds. The channels are divided into equal groups that are served one after another inside a repeating frame, so that only one group is ever producing pulses. All timing is counted in ticks of a 1 µs strobe, so the clock frequency only sets resolution, not timing.

When a group starts, its widths are captured and ranked from shortest to longest. The shortest channel rises first and each further channel rises a fixed stagger later, so no two rising edges coincide. Each line then stays high for exactly its own width. A busy flag marks the span from a group's first rising edge to its last falling edge. Every output change appears one clock after the tick that causes it. The channel count must be a multiple of the group size, and the frame must be long enough to hold every group.

Top module: `servo_stagger`

## Requirements
- R1: Channel c belongs to group c / GROUP_SIZE; groups are served in ascending order within a frame, and lines of two different groups are never high together.
- R2: The first frame begins on the first tick after reset is released; each later frame begins FRAME_US + 1 ticks after the previous one (more than FRAME_US elapsed).
- R3: Group g + 1 begins GP + 1 ticks after group g, where GP = MAX_WIDTH_US + GROUP_SIZE × STAGGER_US (2260 with the defaults).
- R4: Within a group, the channel of rank r (r = 0 for the shortest width) rises r × STAGGER_US ticks after the group's first rising edge.
- R5: Among equal widths in one group, the lower-numbered channel takes the lower rank.
- R6: Each line stays high for exactly its width in ticks; widths are read as unsigned WIDTH_W-bit fields, channel c at bits [c×WIDTH_W +: WIDTH_W], expected between 1 and MAX_WIDTH_US.
- R7: A group's widths are captured when that group begins; changes after that point only take effect the next time that group begins.
- R8: busy rises together with a group's first rising edge and falls together with its last falling edge, and it is low between groups.
- R9: While reset is held, and until the first frame, every line and busy are low.
- R10: All durations count ticks, so with one tick every D clocks every spacing and width stretches by exactly D clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| widths_us | input | NUM_CH×WIDTH_W | Pulse width per channel in microseconds |
| pulse_out | output | NUM_CH | Servo pulse lines |
| busy | output | 1 | High while the current group has pulses in progress |

## Verification
On every cycle the assertions check that at most one group has lines high, that at most one line rises per clock, that busy covers every high line and drops exactly with the last falling edge, that a frame only starts after the last group, and that the captured ranks are distinct. Only the bench scenarios can show the actual arithmetic: the rank-ordered stagger offsets, exact pulse lengths, group and frame spacing, the tie rule, capture at group start against a mid-frame update, and the stretch under a slower tick.

// File: rtl/servo_stagger_pkg.sv
package servo_stagger_pkg;

    // Time inside a group, in microseconds; must cover MAX_WIDTH + stagger span.
    localparam int unsigned SLOT_TIME_W = 16;

    typedef logic [SLOT_TIME_W-1:0] slot_time_t;

    // Window of one slot relative to the start of its group.
    typedef struct packed {
        slot_time_t rise;
        slot_time_t fall;
    } slot_win_t;

    // Ordering used for the stagger: shorter first, lower index wins a tie.
    function automatic logic goes_first(input slot_time_t w_a, input int unsigned idx_a,
                                        input slot_time_t w_b, input int unsigned idx_b);
        return (w_a < w_b) || ((w_a == w_b) && (idx_a < idx_b));
    endfunction

    function automatic int unsigned group_period(input int unsigned max_w,
                                                 input int unsigned gsize,
                                                 input int unsigned stagger);
        return max_w + gsize * stagger;
    endfunction

endpackage

// File: rtl/servo_stagger_timebase.sv
module servo_stagger_timebase
    import servo_stagger_pkg::*;
#(
    parameter int unsigned FRAME_US        = 20000,
    parameter int unsigned GROUP_PERIOD_US = 2260,
    parameter int unsigned NUM_GROUPS      = 3,
    localparam int unsigned GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int unsigned FT_W  = $clog2(FRAME_US + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_us,
    output logic             grp_start,
    output logic [GRP_W-1:0] grp_next,
    output logic [GRP_W-1:0] grp_q,
    output slot_time_t       gt_q
);

    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);
    localparam slot_time_t       GP_T     = slot_time_t'(GROUP_PERIOD_US);
    localparam logic [FT_W-1:0]  FT_END   = FT_W'(FRAME_US);

    logic [FT_W-1:0] ft_q;
    logic            frame_go;
    logic            group_go;

    always_comb begin
        frame_go  = tick_us && (ft_q == FT_END);
        group_go  = tick_us && !frame_go && (gt_q == GP_T) && (grp_q != LAST_GRP);
        grp_start = frame_go || group_go;
        if (frame_go) begin
            grp_next = '0;
        end else if (group_go) begin
            grp_next = grp_q + GRP_W'(1);
        end else begin
            grp_next = grp_q;
        end
    end

    // Frame counter starts saturated so the first tick opens a frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            ft_q  <= FT_END;
            gt_q  <= GP_T;
            grp_q <= LAST_GRP;
        end else if (tick_us) begin
            ft_q  <= frame_go ? '0 : ft_q + FT_W'(1);
            grp_q <= grp_next;
            if (grp_start) begin
                gt_q <= '0;
            end else if (gt_q != GP_T) begin
                gt_q <= gt_q + slot_time_t'(1);
            end
        end
    end

    AST_FRAME_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        frame_go |-> (grp_q == LAST_GRP && gt_q == GP_T)); // R2

endmodule

// File: rtl/servo_stagger_sched.sv
module servo_stagger_sched
    import servo_stagger_pkg::*;
#(
    parameter int unsigned GROUP_SIZE = 6,
    parameter int unsigned WIDTH_W    = 12,
    parameter int unsigned STAGGER_US = 10,
    localparam int unsigned GRP_BITS  = GROUP_SIZE * WIDTH_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            load,
    input  logic [GRP_BITS-1:0]             grp_widths,
    output slot_win_t [GROUP_SIZE-1:0]      win_q,
    output slot_time_t                      last_fall_q
);

    slot_time_t                 width_t [GROUP_SIZE];
    slot_time_t                 rank    [GROUP_SIZE];
    slot_win_t [GROUP_SIZE-1:0] win_d;
    slot_time_t                 last_fall_d;
    logic                       rank_clash;

    generate
        for (genvar i = 0; i < GROUP_SIZE; i++) begin : g_unpack
            assign width_t[i] = slot_time_t'(grp_widths[i*WIDTH_W +: WIDTH_W]);
        end
    endgenerate

    // Rank = number of slots that go before this one.
    always_comb begin
        for (int unsigned i = 0; i < GROUP_SIZE; i++) begin
            rank[i] = '0;
            for (int unsigned j = 0; j < GROUP_SIZE; j++) begin
                if (j != i && goes_first(width_t[j], j, width_t[i], i)) begin
                    rank[i] = rank[i] + slot_time_t'(1);
                end
            end
        end
    end

    always_comb begin
        last_fall_d = '0;
        for (int unsigned i = 0; i < GROUP_SIZE; i++) begin
            win_d[i].rise = rank[i] * slot_time_t'(STAGGER_US);
            win_d[i].fall = win_d[i].rise + width_t[i];
            if (win_d[i].fall > last_fall_d) begin
                last_fall_d = win_d[i].fall;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q       <= '0;
            last_fall_q <= '0;
        end else if (load) begin
            win_q       <= win_d;
            last_fall_q <= last_fall_d;
        end
    end

    always_comb begin
        rank_clash = 1'b0;
        for (int unsigned i = 0; i < GROUP_SIZE; i++) begin
            for (int unsigned j = i + 1; j < GROUP_SIZE; j++) begin
                if (rank[i] == rank[j]) rank_clash = 1'b1;
            end
        end
    end

    AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        load |-> !rank_clash); // R5

endmodule

// File: rtl/servo_stagger_outs.sv
module servo_stagger_outs
    import servo_stagger_pkg::*;
#(
    parameter int unsigned NUM_CH     = 18,
    parameter int unsigned GROUP_SIZE = 6,
    parameter int unsigned GRP_W      = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [GRP_W-1:0]           grp_q,
    input  slot_time_t                 gt_q,
    input  slot_win_t [GROUP_SIZE-1:0] win_q,
    input  slot_time_t                 last_fall_q,
    output logic [NUM_CH-1:0]          pulse_q,
    output logic                       busy_q
);

    logic [NUM_CH-1:0] hit;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            localparam int unsigned GRP  = ch / GROUP_SIZE;
            localparam int unsigned SLOT = ch % GROUP_SIZE;
            assign hit[ch] = (grp_q == GRP_W'(GRP))
                          && (gt_q >= win_q[SLOT].rise)
                          && (gt_q <  win_q[SLOT].fall);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
            busy_q  <= 1'b0;
        end else begin
            pulse_q <= hit;
            busy_q  <= (gt_q < last_fall_q);
        end
    end

endmodule

// File: rtl/servo_stagger.sv
module servo_stagger
    import servo_stagger_pkg::*;
#(
    parameter int unsigned NUM_CH       = 18,
    parameter int unsigned GROUP_SIZE   = 6,
    parameter int unsigned WIDTH_W      = 12,
    parameter int unsigned MAX_WIDTH_US = 2200,
    parameter int unsigned STAGGER_US   = 10,
    parameter int unsigned FRAME_US     = 20000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick_us,
    input  logic [NUM_CH*WIDTH_W-1:0] widths_us,
    output logic [NUM_CH-1:0]         pulse_out,
    output logic                      busy
);

    localparam int unsigned NUM_GROUPS = NUM_CH / GROUP_SIZE;
    localparam int unsigned GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int unsigned GRP_BITS   = GROUP_SIZE * WIDTH_W;
    localparam int unsigned GP_US      = group_period(MAX_WIDTH_US, GROUP_SIZE, STAGGER_US);

    logic                       grp_start;
    logic [GRP_W-1:0]           grp_next;
    logic [GRP_W-1:0]           grp_q;
    slot_time_t                 gt_q;
    logic [GRP_BITS-1:0]        grp_widths;
    slot_win_t [GROUP_SIZE-1:0] win_q;
    slot_time_t                 last_fall_q;

    servo_stagger_timebase #(
        .FRAME_US        (FRAME_US),
        .GROUP_PERIOD_US (GP_US),
        .NUM_GROUPS      (NUM_GROUPS)
    ) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .tick_us   (tick_us),
        .grp_start (grp_start),
        .grp_next  (grp_next),
        .grp_q     (grp_q),
        .gt_q      (gt_q)
    );

    // Select the widths of the group about to start.
    always_comb begin
        grp_widths = '0;
        for (int unsigned g = 0; g < NUM_GROUPS; g++) begin
            if (grp_next == GRP_W'(g)) begin
                grp_widths = widths_us[g*GRP_BITS +: GRP_BITS];
            end
        end
    end

    servo_stagger_sched #(
        .GROUP_SIZE (GROUP_SIZE),
        .WIDTH_W    (WIDTH_W),
        .STAGGER_US (STAGGER_US)
    ) u_sched (
        .clk         (clk),
        .rst         (rst),
        .load        (grp_start),
        .grp_widths  (grp_widths),
        .win_q       (win_q),
        .last_fall_q (last_fall_q)
    );

    servo_stagger_outs #(
        .NUM_CH     (NUM_CH),
        .GROUP_SIZE (GROUP_SIZE),
        .GRP_W      (GRP_W)
    ) u_outs (
        .clk         (clk),
        .rst         (rst),
        .grp_q       (grp_q),
        .gt_q        (gt_q),
        .win_q       (win_q),
        .last_fall_q (last_fall_q),
        .pulse_q     (pulse_out),
        .busy_q      (busy)
    );

    logic [NUM_GROUPS-1:0] grp_any;

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_any
            assign grp_any[g] = |pulse_out[g*GROUP_SIZE +: GROUP_SIZE];
        end
    endgenerate

    AST_ONE_GROUP_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grp_any)); // R1

    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
        $countones(pulse_out & ~$past(pulse_out)) <= 1); // R4

    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
        (|pulse_out) |-> busy); // R8

    AST_BUSY_DROPS_WITH_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $fell(|pulse_out)); // R8

endmodule

// File: tb/servo_stagger_test.sv
module servo_stagger_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 9;
    localparam int GS    = 3;
    localparam int NG    = NCH / GS;
    localparam int WW    = 8;
    localparam int MAXW  = 60;
    localparam int ST    = 4;
    localparam int FRAME = 800;
    localparam int GP    = MAXW + GS * ST;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic [NCH*WW-1:0] widths = '0;
    logic [NCH-1:0]    pulses;
    logic              busy;

    int tests = 0, fails = 0, cyc = 0, tick_div = 1;
    int exp_w [NCH];
    int nw    [NCH];
    int rise_c [NCH];
    int fall_c [NCH];
    int brise [NG];
    int bfall [NG];
    int groups_seen = 0, fs = 0, prev_fs = 0, rel_cyc = 0;
    bit overlap = 1'b0;

    servo_stagger #(
        .NUM_CH (NCH), .GROUP_SIZE (GS), .WIDTH_W (WW),
        .MAX_WIDTH_US (MAXW), .STAGGER_US (ST), .FRAME_US (FRAME)
    ) uut (
        .clk (clk), .rst (rst), .tick_us (tick), .widths_us (widths),
        .pulse_out (pulses), .busy (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Tick strobe: one in every tick_div clocks.
    initial begin
        int dc;
        dc = 0;
        forever begin
            @(negedge clk);
            dc = dc + 1;
            if (dc >= tick_div) dc = 0;
            tick = (dc == 0);
        end
    end

    // Edge recorder.
    initial begin
        logic [NCH-1:0] pp;
        logic           pb;
        int             nact;
        pp = '0;
        pb = 1'b0;
        forever begin
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++) begin
                if (pulses[ch] && !pp[ch]) rise_c[ch] = cyc;
                if (!pulses[ch] && pp[ch]) fall_c[ch] = cyc;
            end
            if (busy && !pb) begin
                brise[groups_seen % NG] = cyc;
                if (groups_seen % NG == 0) begin
                    prev_fs = fs;
                    fs = cyc;
                end
                groups_seen++;
            end
            if (!busy && pb) bfall[(groups_seen - 1) % NG] = cyc;
            nact = 0;
            for (int g = 0; g < NG; g++) begin
                logic [NCH-1:0] gm;
                gm = NCH'((1 << GS) - 1) << (g * GS);
                if ((pulses & gm) != '0) nact++;
            end
            if (nact > 1) overlap = 1'b1;
            pp = pulses;
            pb = busy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog: got no completion expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(int got, int expv, string tag, string what);
        tests++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    task automatic load_widths(input int src [NCH]);
        for (int ch = 0; ch < NCH; ch++) widths[ch*WW +: WW] = WW'(src[ch]);
    endtask

    task automatic do_reset(int div);
        rst = 1'b1;
        tick_div = div;
        repeat (5) step();
        chk(int'(pulses), 0, "R9", "lines during reset");
        chk(int'(busy), 0, "R9", "busy during reset");
        groups_seen = 0;
        fs = 0;
        prev_fs = 0;
        overlap = 1'b0;
        rst = 1'b0;
        rel_cyc = cyc;
        step();
        chk(int'(pulses), 0, "R9", "lines right after reset");
    endtask

    task automatic wait_frame();
        int tgt;
        tgt = (groups_seen / NG + 1) * NG;
        do step(); while (!(groups_seen >= tgt && !busy));
    endtask

    task automatic check_frame(int d, string ctx);
        for (int g = 0; g < NG; g++) begin
            int mx;
            mx = 0;
            if (g > 0)
                chk(brise[g] - brise[g-1], (GP + 1) * d, "R3", $sformatf("%s group %0d spacing", ctx, g));
            for (int s = 0; s < GS; s++) begin
                int ch, rank;
                bit tie;
                ch = g * GS + s;
                rank = 0;
                tie = 1'b0;
                for (int j = g * GS; j < (g + 1) * GS; j++) begin
                    if (j != ch) begin
                        if (exp_w[j] < exp_w[ch] || (exp_w[j] == exp_w[ch] && j < ch)) rank++;
                        if (exp_w[j] == exp_w[ch]) tie = 1'b1;
                    end
                end
                chk(rise_c[ch] - brise[g], rank * ST * d, tie ? "R5" : "R4",
                    $sformatf("%s ch%0d rise offset", ctx, ch));
                chk(fall_c[ch] - rise_c[ch], exp_w[ch] * d, (d == 1) ? "R6" : "R10",
                    $sformatf("%s ch%0d width", ctx, ch));
                if (fall_c[ch] > mx) mx = fall_c[ch];
            end
            chk(bfall[g], mx, "R8", $sformatf("%s group %0d busy fall", ctx, g));
        end
        chk(int'(overlap), 0, "R1", $sformatf("%s groups overlapping", ctx));
        overlap = 1'b0;
        if (groups_seen / NG >= 2)
            chk(fs - prev_fs, (FRAME + 1) * d, (d == 1) ? "R2" : "R10", $sformatf("%s frame spacing", ctx));
    endtask

    initial begin
        // Ascending widths, first frame after reset.
        for (int ch = 0; ch < NCH; ch++) exp_w[ch] = 10 + 5 * ch;
        load_widths(exp_w);
        do_reset(1);
        wait_frame();
        chk(brise[0] - rel_cyc, 2, "R2", "first frame start after reset");
        check_frame(1, "ascending");

        // Descending widths.
        for (int ch = 0; ch < NCH; ch++) exp_w[ch] = MAXW - 5 * ch;
        load_widths(exp_w);
        wait_frame();
        check_frame(1, "descending");

        // All equal: order by channel number.
        for (int ch = 0; ch < NCH; ch++) exp_w[ch] = 33;
        load_widths(exp_w);
        wait_frame();
        check_frame(1, "all equal");

        // Partial ties.
        for (int ch = 0; ch < NCH; ch++) exp_w[ch] = 20 + 10 * ((ch + 1) % 2);
        load_widths(exp_w);
        wait_frame();
        check_frame(1, "pair ties");

        // Arithmetic sweep, including MAXW and the minimum.
        for (int s = 0; s < 6; s++) begin
            for (int ch = 0; ch < NCH; ch++) exp_w[ch] = 10 + ((ch * 7 + s * 13) % 51);
            if (s == 5) begin
                exp_w[0] = MAXW;
                exp_w[4] = 1;
            end
            load_widths(exp_w);
            wait_frame();
            check_frame(1, $sformatf("sweep %0d", s));
        end

        // R7: update while group 0 is running.
        for (int ch = 0; ch < NCH; ch++) begin
            exp_w[ch] = 15 + 3 * ch;
            nw[ch]    = 55 - 4 * ch;
        end
        load_widths(exp_w);
        wait_frame();
        check_frame(1, "before update");
        do step(); while (groups_seen % NG != 1);
        repeat (3) step();
        load_widths(nw);
        for (int ch = GS; ch < NCH; ch++) exp_w[ch] = nw[ch];
        wait_frame();
        check_frame(1, "mid-frame update");
        for (int ch = 0; ch < GS; ch++)
            chk(fall_c[ch] - rise_c[ch], 15 + 3 * ch, "R7", $sformatf("ch%0d kept captured width", ch));
        for (int ch = 0; ch < NCH; ch++) exp_w[ch] = nw[ch];
        wait_frame();
        check_frame(1, "after update");
        for (int ch = 0; ch < GS; ch++)
            chk(fall_c[ch] - rise_c[ch], nw[ch], "R7", $sformatf("ch%0d took new width", ch));

        // R10: slower tick.
        for (int ch = 0; ch < NCH; ch++) exp_w[ch] = 12 + ((ch * 11) % 40);
        load_widths(exp_w);
        do_reset(2);
        wait_frame();
        check_frame(2, "half-rate tick");
        exp_w[3] = exp_w[4];
        load_widths(exp_w);
        wait_frame();
        check_frame(2, "half-rate tick ties");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule